// File: doc/BRIEF.md
# Data Bus Turnaround Fill Sequencer

This block sits in the core clock domain next to the driver of a shared, bidirectional system data bus. It watches a stream of data-control commands. A write command starts an outbound burst that drives the bus for a fixed number of beats. A fill command hands the bus to the far side. Three cycles after the fill command the block turns its drivers off, and it cuts short any outbound burst that still has beats left. It then waits for a programmable number of cycles and captures the inbound fill beats on consecutive cycles.

The block does not arbitrate. The external system must schedule fills and writes so that they never collide on the bus. A later write command always wins over a fill that is still running. The fill then stops and the drivers come back on for the write. A fill command that arrives while a fill is running starts the timeline again from the new command.

The capture output is a valid-only stream with no ready input. The inbound bus cannot be stalled, so the consumer must take every beat in the cycle its `cap_valid` is high. No back-pressure exists anywhere in the block.

Top module: `fill_turnaround_seq`

## Requirements
- R1: Only command codes 4'h8, 4'h9, 4'hA, 4'hB and 4'hC (the five fill kinds: plain, error, shared, shared-dirty, dirty) with `cmd_valid` high start a fill. Code 4'h1 is a write. Every other code produces no capture and no abort.
- R2: When a fill command is sampled at edge T, `bus_drive_en` is low from edge T+3 onward, even if a write burst was driving before.
- R3: `wr_abort` pulses for exactly one cycle, registered at edge T+3, if and only if the write burst still has beats left at that edge. A burst whose final beat falls on that edge ends normally with no abort.
- R4: After edge T+3, `bus_drive_en` stays low through the last captured beat unless a write command arrives.
- R5: A write command accepted during a fill cancels all of the fill's remaining captures. `bus_drive_en` is high after that same edge.
- R6: The first beat is captured from `bus_rd` at edge T+10+D, where D is the 5-bit `fill_dly` value. `cap_valid` is high in the cycle that follows that edge.
- R7: A fill delivers BEATS captures (default 8) on consecutive edges. `cap_beat` counts 0 up to BEATS-1, and each `cap_data` equals `bus_rd` at its capture edge.
- R8: D is latched when the fill command is accepted. Later changes on `fill_dly` do not move the capture point.
- R9: A write command with no interruption keeps `bus_drive_en` high for exactly BEATS cycles.
- R10: While `rst_n` is low, and right after it is released, `bus_drive_en`, `wr_abort` and `cap_valid` are low and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_code | input | 4 | Data-control command code |
| cmd_valid | input | 1 | Command code is valid this cycle |
| fill_dly | input | 5 | Capture offset register value D |
| bus_rd | input | 64 | Inbound data sampled from the bus |
| bus_drive_en | output | 1 | Outbound bus drivers enabled |
| wr_abort | output | 1 | One-cycle pulse: outbound burst cut short |
| cap_valid | output | 1 | Captured fill beat valid (no ready) |
| cap_beat | output | 3 | Index of the captured beat |
| cap_data | output | 64 | Captured fill beat data |

## Verification
A wrong cycle count in the fill timeline shows at the ports as a shifted first `cap_valid` or a misplaced `wr_abort`. The shift is visible within ten to forty-one cycles of the command, and it moves with D. A wrong phase after release shows as `bus_drive_en` rising during the quiet window, or as a wrong number of capture strobes. A stale or unlatched delay shows only when `fill_dly` changes in the middle of a fill, so the stimulus changes that input on the cycle after every fill command. A write-beat counter that is off by one shows as a burst one cycle too long or too short, and as an abort that appears or vanishes at the boundary where a burst's last beat falls on the release edge.

// File: rtl/fts_pkg.sv
package fts_pkg;

  localparam int CMD_W = 4;

  localparam logic [CMD_W-1:0] CMD_WRITE       = 4'h1;
  localparam logic [CMD_W-1:0] CMD_FILL_PLAIN  = 4'h8;
  localparam logic [CMD_W-1:0] CMD_FILL_ERR    = 4'h9;
  localparam logic [CMD_W-1:0] CMD_FILL_SHARED = 4'hA;
  localparam logic [CMD_W-1:0] CMD_FILL_SHDIRT = 4'hB;
  localparam logic [CMD_W-1:0] CMD_FILL_DIRTY  = 4'hC;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LAG   = 2'd1,
    PH_QUIET = 2'd2,
    PH_CAPT  = 2'd3
  } fill_phase_e;

  function automatic logic is_fill_code(input logic [CMD_W-1:0] c);
    case (c)
      CMD_FILL_PLAIN, CMD_FILL_ERR, CMD_FILL_SHARED,
      CMD_FILL_SHDIRT, CMD_FILL_DIRTY: is_fill_code = 1'b1;
      default:                         is_fill_code = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fts_cmd_decode.sv
module fts_cmd_decode
  import fts_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             cmd_valid,
  output logic             fill_go,
  output logic             wr_go
);

  always_comb begin
    fill_go = cmd_valid && is_fill_code(cmd_code);
    wr_go   = cmd_valid && (cmd_code == CMD_WRITE);
  end

endmodule

// File: rtl/fts_wr_burst.sv
module fts_wr_burst #(
  parameter int BEATS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_go,
  input  logic kill,
  output logic wr_active,
  output logic wr_abort
);

  localparam int CW = $clog2(BEATS + 1);
  localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_active <= 1'b0;
      wr_abort  <= 1'b0;
      cnt       <= '0;
    end else begin
      wr_abort <= 1'b0;
      if (wr_go) begin
        wr_active <= 1'b1;
        cnt       <= '0;
      end else if (wr_active) begin
        if (cnt == LAST) begin
          wr_active <= 1'b0;
        end else if (kill) begin
          wr_active <= 1'b0;
          wr_abort  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R9
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_active) |-> (wr_abort || $past(cnt) == LAST));

endmodule

// File: rtl/fts_fill_timeline.sv
module fts_fill_timeline
  import fts_pkg::*;
#(
  parameter int BEATS    = 8,
  parameter int DW       = 64,
  parameter int DLY_W    = 5,
  parameter int OFF_LAT  = 3,
  parameter int CAP_BASE = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fill_go,
  input  logic                     wr_go,
  input  logic [DLY_W-1:0]         fill_dly,
  input  logic [DW-1:0]            bus_rd,
  output logic                     kill,
  output logic                     quiet,
  output logic                     cap_valid,
  output logic [$clog2(BEATS)-1:0] cap_beat,
  output logic [DW-1:0]            cap_data
);

  localparam int AW = $clog2(CAP_BASE + (1 << DLY_W) + 1);
  localparam int IW = $clog2(BEATS);
  localparam logic [AW-1:0] OFF_M1  = AW'(OFF_LAT - 1);
  localparam logic [AW-1:0] BASE_M1 = AW'(CAP_BASE - 1);
  localparam logic [IW-1:0] LAST    = IW'(BEATS - 1);

  fill_phase_e      phase;
  logic [AW-1:0]    age;
  logic [DLY_W-1:0] dly_q;
  logic [IW-1:0]    beat;
  logic [AW-1:0]    cap_at;

  assign cap_at = BASE_M1 + AW'(dly_q);
  assign kill   = (phase == PH_LAG) && (age == OFF_M1) && !wr_go && !fill_go;
  assign quiet  = (phase == PH_QUIET) || (phase == PH_CAPT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      age       <= '0;
      dly_q     <= '0;
      beat      <= '0;
      cap_valid <= 1'b0;
      cap_beat  <= '0;
      cap_data  <= '0;
    end else begin
      cap_valid <= 1'b0;
      if (wr_go) begin
        phase <= PH_IDLE;
      end else if (fill_go) begin
        phase <= PH_LAG;
        age   <= '0;
        dly_q <= fill_dly;
      end else begin
        case (phase)
          PH_LAG: begin
            age <= age + 1'b1;
            if (age == OFF_M1) phase <= PH_QUIET;
          end
          PH_QUIET: begin
            age <= age + 1'b1;
            if (age == cap_at) begin
              cap_valid <= 1'b1;
              cap_beat  <= '0;
              cap_data  <= bus_rd;
              beat      <= IW'(1);
              phase     <= PH_CAPT;
            end
          end
          PH_CAPT: begin
            cap_valid <= 1'b1;
            cap_beat  <= beat;
            cap_data  <= bus_rd;
            beat      <= beat + 1'b1;
            if (beat == LAST) phase <= PH_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  // R1
  fill_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_LAG && !fill_go) |=> (phase != PH_LAG));

  // R7
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && cap_beat != '0) |->
      ($past(cap_valid) && cap_beat == IW'($past(cap_beat) + 1'b1)));

endmodule

// File: rtl/fill_turnaround_seq.sv
module fill_turnaround_seq
  import fts_pkg::*;
#(
  parameter int BEATS    = 8,
  parameter int DW       = 64,
  parameter int DLY_W    = 5,
  parameter int OFF_LAT  = 3,
  parameter int CAP_BASE = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CMD_W-1:0]         cmd_code,
  input  logic                     cmd_valid,
  input  logic [DLY_W-1:0]         fill_dly,
  input  logic [DW-1:0]            bus_rd,
  output logic                     bus_drive_en,
  output logic                     wr_abort,
  output logic                     cap_valid,
  output logic [$clog2(BEATS)-1:0] cap_beat,
  output logic [DW-1:0]            cap_data
);

  logic fill_go, wr_go, kill, quiet, wr_active;

  fts_cmd_decode u_dec (
    .cmd_code (cmd_code),
    .cmd_valid(cmd_valid),
    .fill_go  (fill_go),
    .wr_go    (wr_go)
  );

  fts_wr_burst #(.BEATS(BEATS)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_go    (wr_go),
    .kill     (kill),
    .wr_active(wr_active),
    .wr_abort (wr_abort)
  );

  fts_fill_timeline #(
    .BEATS(BEATS), .DW(DW), .DLY_W(DLY_W),
    .OFF_LAT(OFF_LAT), .CAP_BASE(CAP_BASE)
  ) u_tl (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill_go  (fill_go),
    .wr_go    (wr_go),
    .fill_dly (fill_dly),
    .bus_rd   (bus_rd),
    .kill     (kill),
    .quiet    (quiet),
    .cap_valid(cap_valid),
    .cap_beat (cap_beat),
    .cap_data (cap_data)
  );

  assign bus_drive_en = wr_active;

  // R5
  wr_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> bus_drive_en);

  // R4
  quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !wr_go) |=> !bus_drive_en);

  // R3
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort |-> (!bus_drive_en && $past(bus_drive_en)));

endmodule

// File: tb/fill_turnaround_seq_tb_top.sv
module fill_turnaround_seq_tb_top;

  localparam int BEATS = 8;
  localparam int NROW  = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cmd_code = '0;
  logic        cmd_valid = 1'b0;
  logic [4:0]  fill_dly = '0;
  logic [63:0] bus_rd = '0;
  logic        bus_drive_en, wr_abort, cap_valid;
  logic [2:0]  cap_beat;
  logic [63:0] cap_data;

  always #4 clk = ~clk;

  fill_turnaround_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_valid(cmd_valid),
    .fill_dly(fill_dly), .bus_rd(bus_rd), .bus_drive_en(bus_drive_en),
    .wr_abort(wr_abort), .cap_valid(cap_valid), .cap_beat(cap_beat),
    .cap_data(cap_data)
  );

  // row: cmd[14:11] dly[10:6] lead[5:2] exp_fill[1] exp_abort[0]
  localparam logic [14:0] ROWS [NROW] = '{
    {4'h8, 5'd0,  4'd0, 1'b1, 1'b0},
    {4'h9, 5'd5,  4'd0, 1'b1, 1'b0},
    {4'hA, 5'd31, 4'd0, 1'b1, 1'b0},
    {4'hB, 5'd12, 4'd2, 1'b1, 1'b1},
    {4'hC, 5'd7,  4'd4, 1'b1, 1'b1},
    {4'h8, 5'd3,  4'd5, 1'b1, 1'b0},
    {4'h0, 5'd4,  4'd0, 1'b0, 1'b0},
    {4'h3, 5'd9,  4'd0, 1'b0, 1'b0},
    {4'hF, 5'd1,  4'd1, 1'b0, 1'b0},
    {4'hD, 5'd2,  4'd0, 1'b0, 1'b0},
    {4'h9, 5'd1,  4'd1, 1'b1, 1'b1}
  };

  int errors = 0, checks = 0;
  int first_cap, cap_cnt, abort_cnt, abort_k, drv_bad, idx_bad, data_bad;
  logic drv2, drv3, drv_wr;

  function automatic logic [63:0] pat(input int row, input int k);
    pat = {16'hC0DE, 8'(row), 8'(k), 32'(k) * 32'h0101_0101};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // Runs one command episode; edge T is the edge that samples the command.
  task automatic episode(input logic [3:0] c, input logic [4:0] d,
                         input int lead, input int row, input int wr_k);
    first_cap = -1; cap_cnt = 0; abort_cnt = 0; abort_k = -1;
    drv_bad = 0; idx_bad = 0; data_bad = 0; drv2 = 0; drv3 = 0; drv_wr = 0;
    if (lead > 0) begin
      cmd_code = 4'h1; cmd_valid = 1'b1;
      @(negedge clk); cmd_valid = 1'b0;
      repeat (lead - 1) @(negedge clk);
    end
    cmd_code = c; cmd_valid = 1'b1; fill_dly = d; bus_rd = pat(row, 0);
    for (int k = 0; k <= 60; k++) begin
      @(negedge clk);
      if (k == 0) begin cmd_valid = 1'b0; fill_dly = ~d; end
      cmd_valid = 1'b0;
      if (cap_valid) begin
        if (first_cap < 0) first_cap = k;
        if (int'(cap_beat) != cap_cnt) idx_bad++;
        if (cap_data != pat(row, k)) data_bad++;
        cap_cnt++;
      end
      if (wr_abort) begin abort_cnt++; abort_k = k; end
      if (k == 2) drv2 = bus_drive_en;
      if (k == 3) drv3 = bus_drive_en;
      if (wr_k >= 0 && k == wr_k + 1) drv_wr = bus_drive_en;
      if (wr_k < 0 && k >= 3 && bus_drive_en) drv_bad++;
      if (k == wr_k) begin cmd_code = 4'h1; cmd_valid = 1'b1; end
      bus_rd = pat(row, k + 1);
    end
    cmd_valid = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(!bus_drive_en && !wr_abort && !cap_valid, "R10", "outputs in reset",
        {bus_drive_en, wr_abort, cap_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_drive_en && !wr_abort && !cap_valid, "R10", "outputs after release",
        {bus_drive_en, wr_abort, cap_valid}, 0);

    // Table walk: R1 R2 R3 R4 R6 R7 R8
    for (int r = 0; r < NROW; r++) begin
      logic [3:0] c;
      logic [4:0] d;
      int lead;
      bit ef, ea;
      c = ROWS[r][14:11]; d = ROWS[r][10:6]; lead = int'(ROWS[r][5:2]);
      ef = ROWS[r][1]; ea = ROWS[r][0];
      episode(c, d, lead, r, -1);
      if (ef) begin
        chk(first_cap == 10 + int'(d), "R6", "first capture cycle (R8 latched)",
            first_cap, 10 + int'(d));
        chk(cap_cnt == BEATS, "R7", "beat count", cap_cnt, BEATS);
        chk(idx_bad == 0 && data_bad == 0, "R7", "beat index/data mismatches",
            idx_bad + data_bad, 0);
        chk(drv_bad == 0, "R4", "drive cycles after release", drv_bad, 0);
        if (lead > 0 && lead <= 5)
          chk(drv2 && !drv3, "R2", "drive at k2/k3", {drv2, drv3}, 2);
      end else begin
        chk(cap_cnt == 0, "R1", "captures for non-fill code", cap_cnt, 0);
      end
      if (ea)
        chk(abort_cnt == 1 && abort_k == 3, "R3", "abort pulse at T+3",
            abort_k, 3);
      else
        chk(abort_cnt == 0, "R3", "no abort expected", abort_cnt, 0);
    end

    // R9: plain write burst length
    begin
      int hi = 0;
      cmd_code = 4'h1; cmd_valid = 1'b1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk); cmd_valid = 1'b0;
        if (bus_drive_en) hi++;
        if (wr_abort) hi += 100;
      end
      chk(hi == BEATS, "R9", "write drive cycles", hi, BEATS);
    end

    // R5: write during quiet window cancels the whole fill
    episode(4'h8, 5'd20, 0, 20, 12);
    chk(drv_wr, "R5", "drive after override in quiet", drv_wr, 1);
    chk(cap_cnt == 0, "R5", "captures after quiet override", cap_cnt, 0);

    // R5: write during capture stops the rest of the beats
    episode(4'hA, 5'd0, 0, 21, 13);
    chk(drv_wr, "R5", "drive after override in capture", drv_wr, 1);
    chk(cap_cnt == 4, "R5", "captures before override", cap_cnt, 4);

    // R10: reset in the middle of a capture run
    cmd_code = 4'h8; cmd_valid = 1'b1; fill_dly = 5'd0;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (11) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!cap_valid && !bus_drive_en && !wr_abort, "R10", "outputs at mid-fill reset",
        {bus_drive_en, wr_abort, cap_valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (cap_valid || bus_drive_en) seen++;
      end
      chk(seen == 0, "R10", "activity after mid-fill reset", seen, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule